// File: doc/BRIEF.md
# Fluorescent Display Auto-Refresh Controller

This block refreshes a multiplexed vacuum fluorescent display with no CPU work once it is set up. A CPU fills a byte-wide display memory that appears as a window in its address space and writes a pointer reload value. A free-running slot timer then walks a down-counting pointer through the timing slots. At every slot boundary the block fetches one byte for each of five segment ports and drives those bytes on its outputs for the whole slot.

Three scan modes are selected by the `scan_mode` input. Two modes use 16 timings per frame. One mode uses 32 timings per frame. In the gradation mode a second memory plane supplies one dark-control bit per segment. A dark segment is lit only for the first quarter of its slot, so it looks dimmer than a bright segment. The pointer value of the current slot is exported on `slot_idx`, and `slot_start` marks the first cycle of each slot, so that an external grid driver can follow the scan.

Top module: `vfd_scan_ctrl`

## Requirements
- R1: Mode encoding on `scan_mode`: 0 means 16 timings, 1 means 16 timings with gradation, 2 means 32 timings, and 3 behaves like 0. In both 16-timing modes, the byte shown on port k (bits `seg_out[8k+7:8k]`, k = 0..4) during the slot with offset n is the byte at address 0x0FB0 + 16·k + n.
- R2: In the 32-timing mode, the byte shown on port k during the slot with offset n is the byte at address 0x0F60 + 32·k + n.
- R3: In gradation mode, the dark-control byte for port k at offset n sits at address 0x0F60 + 16·k + n, which is the display address minus 0x50. A control bit of 1 drives its segment only during the first SLOT_CYCLES/4 cycles of the slot and 0 after that. A control bit of 0 drives the segment for the whole slot. In the other modes no segment is ever cut.
- R4: The slot offsets descend by one per slot. The slot after offset 0 uses the reload value. In the 16-timing modes only reload bits 3:0 are used. In the 32-timing mode reload bits 4:0 are used.
- R5: The reload register is accessed with `reg_sel` = 1. Reading it returns 0 in bits 7:5 and the written value in bits 4:0.
- R6: After reset, `seg_out`, `slot_idx` and `slot_start` are 0, the reload register reads 0x1F, and every display byte reads 0.
- R7: A CPU write to an address outside 0x0F60–0x0FFF changes no stored byte. A CPU read of such an address returns 0.
- R8: A CPU read of a window byte returns, in the same cycle, the value most recently written to that byte.
- R9: If a CPU write and a slot fetch hit the same byte in the same cycle, the slot shows the old byte.
- R10: `slot_start` is a one-cycle pulse every SLOT_CYCLES cycles. `seg_out` and `slot_idx` change only in the cycle where `slot_start` is high, or, in gradation mode only, at the quarter point of the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_mode | input | 2 | Scan mode select (see R1) |
| reg_sel | input | 1 | 1 = the CPU access targets the reload register, 0 = the memory window |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data (combinational) |
| seg_out | output | 40 | Segment bytes, port k in bits 8k+7:8k |
| slot_idx | output | 5 | Pointer offset of the current slot |
| slot_start | output | 1 | High in the first cycle of each slot |

## Verification
The bench uses the default parameters: five ports, 16 and 32 timings, and an 8-cycle slot. With these values the quarter point falls two cycles into the slot, so a bright sample and a dimmed sample can both be taken within one slot. With 16 and 32 timings, full pointer wraps complete within a few hundred cycles. The whole 160-byte window is filled with a varied pattern. This lets every port region, the gradation plane and both pointer masks be compared against a bench-side copy of the memory. A pointer left above 15 by the 32-timing mode is also walked down after a switch back to a 16-timing mode.

// File: rtl/vfd_scan_pkg.sv
// Package: shared mode encoding for the display refresh controller.
// Assumes: scan_mode is decoded once at the top and passed as flags.
package vfd_scan_pkg;

    typedef enum logic [1:0] {
        MODE_ORD16  = 2'd0,
        MODE_GRAD16 = 2'd1,
        MODE_T32    = 2'd2,
        MODE_ALT16  = 2'd3
    } scan_mode_e;

endpackage

// File: rtl/vfd_disp_ram.sv
// Module: display memory. It has one CPU read/write port inside an address
// window, plus combinational scan read ports (one display read and one
// gradation read per segment port).
// Assumes: scan indices are always below DEPTH. Accesses outside the window
// are ignored (writes) or read as zero.
module vfd_disp_ram #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int NUM_PORTS = 5,
    parameter int DEPTH     = 160,
    parameter int WIN_BASE  = 16'h0F60,
    parameter int IDX_W     = $clog2(DEPTH)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   cpu_addr,
    input  logic                                cpu_we,
    input  logic [DATA_W-1:0]                   cpu_wdata,
    output logic [DATA_W-1:0]                   cpu_rdata,
    input  logic [NUM_PORTS-1:0][IDX_W-1:0]     scan_disp_idx,
    input  logic [NUM_PORTS-1:0][IDX_W-1:0]     scan_grad_idx,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]    scan_disp_data,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]    scan_grad_data
);

    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(WIN_BASE + DEPTH);

    logic [DATA_W-1:0]       mem [DEPTH];
    logic                    in_win;
    logic [IDX_W-1:0]        off;
    logic [ADDR_W-IDX_W-1:0] off_unused_hi;

    // Decode the window hit and the byte offset inside it
    assign in_win = (cpu_addr >= WIN_LO) && (cpu_addr < WIN_HI);
    assign {off_unused_hi, off} = cpu_addr - WIN_LO;

    // Storage: cleared by reset, written by the CPU inside the window only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (cpu_we && in_win) begin
            mem[off] <= cpu_wdata;
        end
    end

    // CPU read: the window byte, or zero outside the window
    always_comb begin
        cpu_rdata = '0;
        if (in_win && (32'(off) < DEPTH)) cpu_rdata = mem[off];
    end

    // Scan read ports, one pair per segment port
    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_scan_rd
        assign scan_disp_data[k] = (32'(scan_disp_idx[k]) < DEPTH) ? mem[scan_disp_idx[k]] : '0;
        assign scan_grad_data[k] = (32'(scan_grad_idx[k]) < DEPTH) ? mem[scan_grad_idx[k]] : '0;
    end

    // R8
    wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && in_win) |=> ((cpu_addr != $past(cpu_addr)) || (cpu_rdata == $past(cpu_wdata))));

endmodule

// File: rtl/vfd_slot_timer.sv
// Module: slot timer and scan pointer. A prescaler marks slot ends and the
// quarter point. The pointer counts down once per slot and reloads after 0.
// The reload register lives here.
// Assumes: SLOT_CYCLES >= 4. mode32 selects the full pointer width;
// otherwise the top pointer bit is masked off.
module vfd_slot_timer #(
    parameter int SLOT_CYCLES = 8,
    parameter int PTR_W       = 5,
    parameter int RLD_RST     = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode32,
    input  logic             rld_we,
    input  logic [PTR_W-1:0] rld_wdata,
    output logic [PTR_W-1:0] rld_q,
    output logic             slot_end,
    output logic             quarter_end,
    output logic [PTR_W-1:0] ptr_m
);

    localparam int CNT_W   = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam int QUARTER = SLOT_CYCLES / 4;

    logic [CNT_W-1:0] cnt;
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] eff_rld;

    // Prescaler: cycle position inside the current slot
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (slot_end) cnt <= '0;
        else               cnt <= cnt + CNT_W'(1);
    end

    assign slot_end    = (cnt == CNT_W'(SLOT_CYCLES - 1));
    assign quarter_end = (cnt == CNT_W'(QUARTER - 1));

    // Reload register: keeps the pointer-sized low bits
    always_ff @(posedge clk) begin
        if (!rst_n)      rld_q <= PTR_W'(RLD_RST);
        else if (rld_we) rld_q <= rld_wdata;
    end

    // Mode masking of the reload value and of the live pointer
    assign eff_rld = mode32 ? rld_q : {1'b0, rld_q[PTR_W-2:0]};
    assign ptr_m   = mode32 ? ptr   : {1'b0, ptr[PTR_W-2:0]};

    // Pointer: steps down at each slot end, reloads after zero
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr <= PTR_W'(RLD_RST);
        else if (slot_end) ptr <= (ptr_m == '0) ? eff_rld : ptr_m - PTR_W'(1);
    end

    // R10
    slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end |=> (cnt == '0));

    // R10
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt) < SLOT_CYCLES);

endmodule

// File: rtl/vfd_seg_drive.sv
// Module: segment output registers. At a slot end they capture the fetched
// display bytes and dark masks. In gradation mode the dark segments are
// cleared at the quarter point.
// Assumes: slot_end and quarter_end never coincide (SLOT_CYCLES >= 4).
module vfd_seg_drive #(
    parameter int NUM_PORTS = 5,
    parameter int DATA_W    = 8,
    parameter int PTR_W     = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             grad_en,
    input  logic                             slot_end,
    input  logic                             quarter_end,
    input  logic [PTR_W-1:0]                 ptr_m,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0] disp_data,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0] grad_data,
    output logic [NUM_PORTS*DATA_W-1:0]      seg_q,
    output logic [PTR_W-1:0]                 idx_q,
    output logic                             start_q
);

    logic [NUM_PORTS-1:0][DATA_W-1:0] dark_q;

    // Per-port output byte and dark mask
    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
        // Load at slot end, cut dark segments at the quarter point
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_q[k*DATA_W +: DATA_W] <= '0;
                dark_q[k]                 <= '0;
            end else if (slot_end) begin
                seg_q[k*DATA_W +: DATA_W] <= disp_data[k];
                dark_q[k]                 <= grad_en ? grad_data[k] : '0;
            end else if (quarter_end) begin
                seg_q[k*DATA_W +: DATA_W] <= seg_q[k*DATA_W +: DATA_W] & ~dark_q[k];
            end
        end
    end

    // Slot index and start pulse for the grid side
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= slot_end;
            if (slot_end) idx_q <= ptr_m;
        end
    end

    // R10
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_end && !quarter_end) |=> ($stable(seg_q) && $stable(idx_q)));

    // R3
    quarter_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quarter_end |=> ((seg_q & ~$past(seg_q)) == '0));

    // R10
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);

endmodule

// File: rtl/vfd_scan_ctrl.sv
// Module: top of the fluorescent display refresh controller. It decodes the
// mode, maps the scan pointer to per-port memory indices, and muxes CPU reads
// between the memory window and the reload register.
// Assumes: the 16-timing display area is the top NUM_PORTS*T16 bytes of the
// window, and the gradation plane sits directly below it.
module vfd_scan_ctrl
    import vfd_scan_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int NUM_PORTS   = 5,
    parameter int T16         = 16,
    parameter int SLOT_CYCLES = 8,
    parameter int WIN_BASE    = 16'h0F60
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  scan_mode,
    input  logic                        reg_sel,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic                        cpu_wr,
    input  logic [DATA_W-1:0]           cpu_wdata,
    output logic [DATA_W-1:0]           cpu_rdata,
    output logic [NUM_PORTS*DATA_W-1:0] seg_out,
    output logic [$clog2(2*T16)-1:0]    slot_idx,
    output logic                        slot_start
);

    localparam int T32      = 2 * T16;
    localparam int PTR_W    = $clog2(T32);
    localparam int DEPTH    = NUM_PORTS * T32;
    localparam int IDX_W    = $clog2(DEPTH);
    localparam int DISP16_O = DEPTH - NUM_PORTS * T16;
    localparam int RLD_RST  = T32 - 1;

    scan_mode_e                       mode;
    logic                             mode32;
    logic                             grad_en;
    logic                             slot_end;
    logic                             quarter_end;
    logic [PTR_W-1:0]                 ptr_m;
    logic [PTR_W-1:0]                 rld_q;
    logic [DATA_W-1:0]                ram_rdata;
    logic [NUM_PORTS-1:0][IDX_W-1:0]  disp_idx;
    logic [NUM_PORTS-1:0][IDX_W-1:0]  grad_idx;
    logic [NUM_PORTS-1:0][DATA_W-1:0] disp_data;
    logic [NUM_PORTS-1:0][DATA_W-1:0] grad_data;
    logic                             rld_unused_bits;

    // Mode decode
    assign mode    = scan_mode_e'(scan_mode);
    assign mode32  = (mode == MODE_T32);
    assign grad_en = (mode == MODE_GRAD16);

    // Reload bits above the pointer width are not stored
    assign rld_unused_bits = ^cpu_wdata[DATA_W-1:PTR_W];

    // Per-port memory indices for the current pointer
    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_idx
        assign disp_idx[k] = mode32
            ? IDX_W'(k * T32) + IDX_W'(ptr_m)
            : IDX_W'(DISP16_O + k * T16) + IDX_W'(ptr_m[PTR_W-2:0]);
        assign grad_idx[k] = IDX_W'(k * T16) + IDX_W'(ptr_m[PTR_W-2:0]);
    end

    vfd_disp_ram #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS),
        .DEPTH(DEPTH), .WIN_BASE(WIN_BASE), .IDX_W(IDX_W)
    ) ram_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_we(cpu_wr && !reg_sel),
        .cpu_wdata(cpu_wdata), .cpu_rdata(ram_rdata),
        .scan_disp_idx(disp_idx), .scan_grad_idx(grad_idx),
        .scan_disp_data(disp_data), .scan_grad_data(grad_data)
    );

    vfd_slot_timer #(
        .SLOT_CYCLES(SLOT_CYCLES), .PTR_W(PTR_W), .RLD_RST(RLD_RST)
    ) timer_i (
        .clk(clk), .rst_n(rst_n), .mode32(mode32),
        .rld_we(cpu_wr && reg_sel), .rld_wdata(cpu_wdata[PTR_W-1:0]),
        .rld_q(rld_q), .slot_end(slot_end), .quarter_end(quarter_end),
        .ptr_m(ptr_m)
    );

    vfd_seg_drive #(
        .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .PTR_W(PTR_W)
    ) drive_i (
        .clk(clk), .rst_n(rst_n), .grad_en(grad_en),
        .slot_end(slot_end), .quarter_end(quarter_end), .ptr_m(ptr_m),
        .disp_data(disp_data), .grad_data(grad_data),
        .seg_q(seg_out), .idx_q(slot_idx), .start_q(slot_start)
    );

    // CPU read mux: reload register or memory window
    assign cpu_rdata = reg_sel ? {{(DATA_W-PTR_W){1'b0}}, rld_q} : ram_rdata;

    // R5
    rld_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (cpu_rdata[DATA_W-1:PTR_W] == '0));

    // R4
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_end && !mode32) |=> (slot_idx < PTR_W'(T16)));

endmodule

// File: tb/vfd_scan_ctrl_tb_top.sv
module vfd_scan_ctrl_tb_top;

    localparam int NP = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  scan_mode = 2'd0;
    logic        reg_sel = 1'b0;
    logic [15:0] cpu_addr = 16'h0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = 8'h0;
    logic [7:0]  cpu_rdata;
    logic [39:0] seg_out;
    logic [4:0]  slot_idx;
    logic        slot_start;

    int nvec = 0;
    int nfail = 0;
    logic [7:0] mirror [160];

    always #4 clk = ~clk;

    vfd_scan_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .reg_sel(reg_sel),
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .seg_out(seg_out), .slot_idx(slot_idx),
        .slot_start(slot_start)
    );

    // mode(2) | reload write value(8) | slots to observe(6)
    localparam logic [15:0] VEC [0:6] = '{
        {2'd0, 8'hEF, 6'd20},
        {2'd3, 8'hE5, 6'd10},
        {2'd1, 8'hF7, 6'd12},
        {2'd2, 8'hFF, 6'd36},
        {2'd0, 8'hFA, 6'd24},
        {2'd2, 8'hE9, 6'd14},
        {2'd1, 8'hF0, 6'd4}
    };

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic sel, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic cpu_read(input logic sel, input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; cpu_addr = a;
        #1 d = cpu_rdata;
        reg_sel = 1'b0;
    endtask

    task automatic wait_slot();
        do @(negedge clk); while (!slot_start);
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) ^ (i >> 2));
    endfunction

    function automatic logic [39:0] exp_disp(input logic [1:0] m, input int idx);
        logic [39:0] r;
        for (int k = 0; k < NP; k++)
            r[k*8 +: 8] = (m == 2'd2) ? mirror[32*k + idx] : mirror[80 + 16*k + idx];
        return r;
    endfunction

    function automatic logic [39:0] exp_dark(input logic [1:0] m, input int idx);
        logic [39:0] r;
        for (int k = 0; k < NP; k++)
            r[k*8 +: 8] = (m == 2'd1) ? mirror[16*k + idx] : 8'h00;
        return r;
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        int gap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6 reset state
        #1;
        check("R6 seg_out", seg_out, 40'h0);
        check("R6 slot_idx", 40'(slot_idx), 40'h0);
        check("R6 slot_start", 40'(slot_start), 40'h0);
        cpu_read(1'b1, 16'h0, rd);
        check("R6 reload", 40'(rd), 40'h1F);
        cpu_read(1'b0, 16'h0FA3, rd);
        check("R6 ram cleared", 40'(rd), 40'h0);

        // Fill the whole window with a pattern
        for (int i = 0; i < 160; i++) begin
            mirror[i] = pat(i);
            cpu_write(1'b0, 16'(16'h0F60 + i), pat(i));
        end
        // R8 readback
        for (int i = 0; i < 160; i += 23) begin
            cpu_read(1'b0, 16'(16'h0F60 + i), rd);
            check("R8 readback", 40'(rd), 40'(mirror[i]));
        end

        // R7 outside the window
        cpu_write(1'b0, 16'h0F5F, 8'hAA);
        cpu_write(1'b0, 16'h1000, 8'h55);
        cpu_read(1'b0, 16'h0F5F, rd);
        check("R7 read below", 40'(rd), 40'h0);
        cpu_read(1'b0, 16'h1000, rd);
        check("R7 read above", 40'(rd), 40'h0);
        cpu_read(1'b0, 16'h0F60, rd);
        check("R7 low edge kept", 40'(rd), 40'(mirror[0]));
        cpu_read(1'b0, 16'h0FFF, rd);
        check("R7 high edge kept", 40'(rd), 40'(mirror[159]));

        // R5 reload register readback
        cpu_write(1'b1, 16'h0, 8'hE3);
        cpu_read(1'b1, 16'h0, rd);
        check("R5 hi bits zero", 40'(rd), 40'h03);
        cpu_write(1'b1, 16'h0, 8'h1A);
        cpu_read(1'b1, 16'h0, rd);
        check("R5 bit4 kept", 40'(rd), 40'h1A);

        // R10 slot period
        wait_slot();
        gap = 0;
        do begin @(negedge clk); gap++; end while (!slot_start);
        check("R10 slot period", 40'(gap), 40'd8);

        // Table walk: R1 R2 R3 R4
        foreach (VEC[v]) begin
            logic [1:0] m;
            logic [7:0] w;
            int ns, eff, prev;
            logic [39:0] full, cut;
            m = VEC[v][15:14]; w = VEC[v][13:6]; ns = int'(VEC[v][5:0]);
            eff = (m == 2'd2) ? int'(w[4:0]) : int'(w[3:0]);
            @(negedge clk);
            scan_mode = m;
            cpu_write(1'b1, 16'h0, w);
            prev = -1;
            for (int s = 0; s < ns; s++) begin
                int idx;
                wait_slot();
                idx = int'(slot_idx);
                full = seg_out;
                if (prev >= 0)
                    check("R4 pointer step", 40'(idx), 40'((prev == 0) ? eff : prev - 1));
                check((m == 2'd2) ? "R2 port data" : "R1 port data", full, exp_disp(m, idx));
                repeat (3) @(negedge clk);
                cut = seg_out;
                check("R3 quarter cut", cut, exp_disp(m, idx) & ~exp_dark(m, idx));
                prev = idx;
            end
        end

        // R9 collision: 32-timing mode, reload 9
        begin
            int i0, nxt;
            logic [7:0] oldv;
            @(negedge clk);
            scan_mode = 2'd2;
            cpu_write(1'b1, 16'h0, 8'h09);
            wait_slot();
            wait_slot();
            i0 = int'(slot_idx);
            nxt = (i0 == 0) ? 9 : i0 - 1;
            oldv = mirror[nxt];
            repeat (7) @(negedge clk);
            reg_sel = 1'b0; cpu_addr = 16'(16'h0F60 + nxt); cpu_wdata = ~oldv; cpu_wr = 1'b1;
            @(negedge clk);
            cpu_wr = 1'b0;
            check("R9 slot_start", 40'(slot_start), 40'h1);
            check("R9 idx", 40'(slot_idx), 40'(nxt));
            check("R9 old data", 40'(seg_out[7:0]), 40'(oldv));
            mirror[nxt] = ~oldv;
            cpu_read(1'b0, 16'(16'h0F60 + nxt), rd);
            check("R8 new data", 40'(rd), 40'(mirror[nxt]));
        end

        finish_run();
    end

endmodule